// File: doc/BRIEF.md
# Seconds and Minutes Time Counter

This block keeps the seconds and minutes of a time-of-day display as two chained modulo-60 sections. Each section holds a decimal units digit and a tens digit that runs from 0 to 5. The block runs on one system clock. A one-cycle enable pulse arrives once per second and moves the seconds forward. A seconds rollover moves the minutes forward, and a minutes rollover produces a one-cycle pulse for the hours logic that follows.

A front-panel minute-set input can be held to set the time. It passes through a two-flop synchronizer first. While it is active, the minutes take their step from every one-second pulse instead of from the seconds rollover, so they advance once per second. The seconds keep counting during this time, but their rollover no longer moves the minutes. All carries are enables in the system clock domain. No derived clocks are used.

Top module: `mmss_counter`

## Requirements
- R1: A synchronous reset sets all four digits to 0 and drives hourCarry to 0 in the cycle after the reset edge.
- R2: Each tick moves the seconds units digit up by one from 0 through 9. The tick taken at 9 returns it to 0 and moves the seconds tens digit up by one.
- R3: The seconds tens digit runs from 0 to 5. The tick taken at second 59 returns the seconds to 00.
- R4: With minute-set inactive, the minutes move up by exactly one on the tick that returns the seconds from 59 to 00. They do not move on any other tick.
- R5: The tick that takes the time from 59:59 to 00:00 raises hourCarry for the one cycle after that edge. The minutes read 00 at the same time.
- R6: On a cycle with no tick, all four digits hold their values and hourCarry is 0.
- R7: While the synchronized minute-set is active, every tick moves the minutes up by one and the seconds up by one. A seconds rollover adds no extra minute.
- R8: A minutes rollover from 59 to 00 while minute-set is active still raises hourCarry for one cycle.
- R9: hourCarry is never high in two consecutive cycles.
- R10: minute-set takes effect only after two clock edges of synchronization. A tick sampled on the second edge after minute-set rises still follows the normal rule of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickIn | input | 1 | One-cycle enable, once per second |
| minSetIn | input | 1 | Minute-set request from a held switch, asynchronous |
| secOnes | output | DIGIT_W | Seconds units digit, BCD 0 to 9 |
| secTens | output | DIGIT_W | Seconds tens digit, 0 to 5 |
| minOnes | output | DIGIT_W | Minutes units digit, BCD 0 to 9 |
| minTens | output | DIGIT_W | Minutes tens digit, 0 to 5 |
| hourCarry | output | 1 | One-cycle pulse when the minutes wrap to 00 |

## Verification
The bound checker checks the following on every cycle:
- the digit ranges;
- digits holding still on cycles with no tick;
- the +1 step and the 59-to-00 wrap of the seconds;
- hourCarry being a lone pulse that coincides with minutes at 00;
- the cleared state after reset.

Which source moves the minutes can only be shown by the bench's scenarios:
- the seconds rollover in normal mode;
- every tick while minute-set is held;
- the two-edge latency of the synchronizer;
- an hour carry produced while setting.

The bench's reference model predicts these.

// File: rtl/mmss_pkg.sv
package mmss_pkg;

  // Strobes passed from control to datapath, one bit per advance source.
  typedef struct packed {
    logic secStep;   // advance the seconds section
    logic minStep;   // advance the minutes section
    logic hourStep;  // minutes are wrapping: request an hour advance
  } stepStrobes_t;

  localparam int SECTION_COUNT = 2;
  localparam int SEC_IDX = 0;
  localparam int MIN_IDX = 1;

endpackage

// File: rtl/mmss_digit.sv
module mmss_digit #(
  parameter int MODULUS = 10,
  parameter int WIDTH   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [WIDTH-1:0] value,
  output logic             atMax
);

  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  assign atMax = (value == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (step) begin
      value <= atMax ? '0 : value + 1'b1;
    end
  end

endmodule

// File: rtl/mmss_ctrl.sv
module mmss_ctrl
  import mmss_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         tickIn,
  input  logic         minSetIn,
  input  logic         secFull,
  input  logic         minFull,
  output stepStrobes_t strobes
);

  logic syncStage1;
  logic setActive;

  // Two-flop synchronizer for the asynchronous set switch.
  always_ff @(posedge clk) begin
    if (rst) begin
      syncStage1 <= 1'b0;
      setActive  <= 1'b0;
    end else begin
      syncStage1 <= minSetIn;
      setActive  <= syncStage1;
    end
  end

  // Choose the minute advance source: the raw tick while setting,
  // otherwise the seconds rollover.
  always_comb begin
    strobes.secStep  = tickIn;
    strobes.minStep  = setActive ? tickIn : (tickIn & secFull);
    strobes.hourStep = strobes.minStep & minFull;
  end

endmodule

// File: rtl/mmss_datapath.sv
module mmss_datapath
  import mmss_pkg::*;
#(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MOD  = 6,
  parameter int DIGIT_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  stepStrobes_t        strobes,
  output logic [DIGIT_W-1:0]  unitsOut [SECTION_COUNT],
  output logic [DIGIT_W-1:0]  tensOut  [SECTION_COUNT],
  output logic [SECTION_COUNT-1:0] sectionFull,
  output logic                hourCarry
);

  logic [SECTION_COUNT-1:0] sectionStep;

  assign sectionStep[SEC_IDX] = strobes.secStep;
  assign sectionStep[MIN_IDX] = strobes.minStep;

  for (genvar sec = 0; sec < SECTION_COUNT; sec++) begin : g_section
    logic unitsMax;
    logic tensMax;

    mmss_digit #(.MODULUS(UNITS_MOD), .WIDTH(DIGIT_W)) u_units (
      .clk   (clk),
      .rst   (rst),
      .step  (sectionStep[sec]),
      .value (unitsOut[sec]),
      .atMax (unitsMax)
    );

    mmss_digit #(.MODULUS(TENS_MOD), .WIDTH(DIGIT_W)) u_tens (
      .clk   (clk),
      .rst   (rst),
      .step  (sectionStep[sec] & unitsMax),
      .value (tensOut[sec]),
      .atMax (tensMax)
    );

    assign sectionFull[sec] = unitsMax & tensMax;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hourCarry <= 1'b0;
    end else begin
      hourCarry <= strobes.hourStep;
    end
  end

endmodule

// File: rtl/mmss_counter.sv
module mmss_counter
  import mmss_pkg::*;
#(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MOD  = 6,
  parameter int DIGIT_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tickIn,
  input  logic               minSetIn,
  output logic [DIGIT_W-1:0] secOnes,
  output logic [DIGIT_W-1:0] secTens,
  output logic [DIGIT_W-1:0] minOnes,
  output logic [DIGIT_W-1:0] minTens,
  output logic               hourCarry
);

  stepStrobes_t             strobes;
  logic [SECTION_COUNT-1:0] sectionFull;
  logic [DIGIT_W-1:0]       unitsVec [SECTION_COUNT];
  logic [DIGIT_W-1:0]       tensVec  [SECTION_COUNT];

  mmss_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tickIn   (tickIn),
    .minSetIn (minSetIn),
    .secFull  (sectionFull[SEC_IDX]),
    .minFull  (sectionFull[MIN_IDX]),
    .strobes  (strobes)
  );

  mmss_datapath #(
    .UNITS_MOD (UNITS_MOD),
    .TENS_MOD  (TENS_MOD),
    .DIGIT_W   (DIGIT_W)
  ) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .unitsOut    (unitsVec),
    .tensOut     (tensVec),
    .sectionFull (sectionFull),
    .hourCarry   (hourCarry)
  );

  assign secOnes = unitsVec[SEC_IDX];
  assign secTens = tensVec[SEC_IDX];
  assign minOnes = unitsVec[MIN_IDX];
  assign minTens = tensVec[MIN_IDX];

endmodule

// File: rtl/mmss_counter_checks.sv
module mmss_counter_checks #(
  parameter int UNITS_MOD = 10,
  parameter int TENS_MOD  = 6,
  parameter int DIGIT_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               tickIn,
  input logic [DIGIT_W-1:0] secOnes,
  input logic [DIGIT_W-1:0] secTens,
  input logic [DIGIT_W-1:0] minOnes,
  input logic [DIGIT_W-1:0] minTens,
  input logic               hourCarry
);

  localparam logic [DIGIT_W-1:0] U_LAST = DIGIT_W'(UNITS_MOD - 1);
  localparam logic [DIGIT_W-1:0] T_LAST = DIGIT_W'(TENS_MOD - 1);

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (secOnes == '0 && secTens == '0 && minOnes == '0 &&
             minTens == '0 && !hourCarry));

  assert_units_range_R2: assert property (@(posedge clk) disable iff (rst)
    secOnes <= U_LAST && minOnes <= U_LAST);

  assert_units_step_R2: assert property (@(posedge clk) disable iff (rst)
    (tickIn && secOnes != U_LAST) |=> secOnes == $past(secOnes) + 1'b1);

  assert_tens_range_R3: assert property (@(posedge clk) disable iff (rst)
    secTens <= T_LAST && minTens <= T_LAST);

  assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (tickIn && secOnes == U_LAST && secTens == T_LAST) |=>
      (secOnes == '0 && secTens == '0));

  assert_carry_at_zero_R5: assert property (@(posedge clk) disable iff (rst)
    hourCarry |-> (minOnes == '0 && minTens == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !tickIn |=> ($stable(secOnes) && $stable(secTens) &&
                 $stable(minOnes) && $stable(minTens) && !hourCarry));

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    hourCarry |=> !hourCarry);

endmodule

bind mmss_counter mmss_counter_checks #(
  .UNITS_MOD (UNITS_MOD),
  .TENS_MOD  (TENS_MOD),
  .DIGIT_W   (DIGIT_W)
) u_checks (
  .clk       (clk),
  .rst       (rst),
  .tickIn    (tickIn),
  .secOnes   (secOnes),
  .secTens   (secTens),
  .minOnes   (minOnes),
  .minTens   (minTens),
  .hourCarry (hourCarry)
);

// File: tb/mmss_counter_test.sv
module mmss_counter_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickIn = 1'b0;
  logic       minSetIn = 1'b0;
  logic [3:0] secOnes, secTens, minOnes, minTens;
  logic       hourCarry;

  typedef struct {
    int    s;
    int    m;
    bit    c;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int    modelSec = 0;
  int    modelMin = 0;
  bit    modelSet = 0;
  bit    lastCarry = 0;
  string idleTag = "R1";
  int    checks = 0;
  int    failures = 0;
  bit    done = 0;

  always #4 clk = ~clk;

  mmss_counter uut (
    .clk       (clk),
    .rst       (rst),
    .tickIn    (tickIn),
    .minSetIn  (minSetIn),
    .secOnes   (secOnes),
    .secTens   (secTens),
    .minOnes   (minOnes),
    .minTens   (minTens),
    .hourCarry (hourCarry)
  );

  task automatic compareItem(input expItem_t e);
    checks++;
    if (secOnes !== 4'(e.s % 10) || secTens !== 4'(e.s / 10) ||
        minOnes !== 4'(e.m % 10) || minTens !== 4'(e.m / 10) ||
        hourCarry !== e.c) begin
      failures++;
      $display("FAIL %s: got %0d%0d:%0d%0d carry=%0b expected %02d:%02d carry=%0b",
               e.tag, minTens, minOnes, secTens, secOnes, hourCarry,
               e.m, e.s, e.c);
    end
  endtask

  // Monitor: pops expected results, or checks the hold state when idle.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (!done) begin
        expItem_t e;
        if (expQ.size() > 0) begin
          e = expQ.pop_front();
        end else begin
          e.s = modelSec;
          e.m = modelMin;
          e.c = 1'b0;
          e.tag = lastCarry ? "R9" : idleTag;
        end
        lastCarry = e.c;
        compareItem(e);
      end
    end
  end

  // Driver: one tick, model update, expected item pushed.
  task automatic doTick(input string tag);
    expItem_t e;
    bit secWrap;
    bit minAdv;
    @(negedge clk);
    tickIn = 1'b1;
    secWrap = (modelSec == 59);
    modelSec = (modelSec + 1) % 60;
    minAdv = modelSet ? 1'b1 : secWrap;
    e.c = 1'b0;
    if (minAdv) begin
      if (modelMin == 59) begin
        modelMin = 0;
        e.c = 1'b1;
      end else begin
        modelMin++;
      end
    end
    e.s = modelSec;
    e.m = modelMin;
    e.tag = (e.c && modelSet) ? "R8" : tag;
    expQ.push_back(e);
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReset();
    expItem_t e;
    @(negedge clk);
    rst = 1'b1;
    minSetIn = 1'b0;
    modelSec = 0;
    modelMin = 0;
    modelSet = 0;
    e.s = 0; e.m = 0; e.c = 1'b0; e.tag = "R1";
    expQ.push_back(e);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic report();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(2);
    idleTag = "R6";
    // R2: units count and first wrap into tens
    for (int i = 0; i < 10; i++) doTick("R2");
    idle(5);
    // R3 then R4: run to 00:59, then wrap into the first minute
    for (int i = 0; i < 49; i++) doTick("R3");
    doTick("R4");
    // R5: run to 59:59 and wrap the hour
    for (int i = 0; i < 3539; i++) doTick("R3");
    doTick("R5");
    idle(3);
    // R10: set raised, a tick straight away still follows normal rules
    @(negedge clk);
    minSetIn = 1'b1;
    doTick("R10");
    idle(2);
    modelSet = 1;
    // R7/R8: setting mode crosses a seconds wrap and a minutes wrap
    for (int i = 0; i < 70; i++) doTick("R7");
    @(negedge clk);
    minSetIn = 1'b0;
    idle(3);
    modelSet = 0;
    // R4: normal mode again after release
    for (int i = 0; i < 65; i++) doTick("R4");
    idle(2);
    // R1: reset in mid-run
    doReset();
    idle(3);
    for (int i = 0; i < 12; i++) doTick("R2");
    idle(3);
    report();
  end

endmodule